// File: doc/BRIEF.md
# Open-Drain Multi-Drive Output Stage

This block sits between the data sources of a general-purpose I/O controller and the pads of 32 I/O lines. For each line it picks one of two drivers: the controller's own output data and enable, or a peripheral's output data and enable. A per-line select input makes that choice. It then passes the chosen pair to the pad either unchanged (push-pull) or in shared-line form (open-drain).

In open-drain form a line is driven only when its value is low. When the value is high the output enable is dropped, so an external or internal pull-up sets the level and several devices can share the wire. Each line has a mode bit that chooses between the two forms. The mode bit applies to the line in the same way whichever source owns it.

Software changes the mode bits through two write strobes that share one data word. One strobe sets the bits that are written as 1. The other strobe clears them. The current mode word is always visible on a status output. The asynchronous reset is released through a short synchronizer, so mode writes take effect starting with the third rising clock edge after reset is released.

Top module: `mdrv_out_stage`

## Requirements
- R1: While reset is asserted, and after it is released, the mode status output reads all zeros until a write changes it.
- R2: A cycle with only the set strobe high sets every mode bit whose `mode_wdata` bit is 1, starting with the next cycle's status. All other mode bits keep their values.
- R3: A cycle with only the clear strobe high clears every mode bit whose `mode_wdata` bit is 1, starting with the next cycle's status. All other mode bits keep their values.
- R4: When both strobes are high in the same cycle, clear wins. The bits written as 1 end up at 0, and the other mode bits are unchanged.
- R5: For each line, select bit 0 chooses the controller's data and enable, and select bit 1 chooses the peripheral's data and enable.
- R6: A line whose mode bit is 0 (push-pull) drives the selected value on `pad_out` and the selected enable on `pad_oe`, both unchanged.
- R7: A line whose mode bit is 1 (open-drain) always presents 0 on `pad_out`. Its `pad_oe` is 1 only when the selected enable is 1 and the selected value is 0.
- R8: The open-drain conversion of R7 applies equally to lines that select the peripheral.
- R9: In a cycle with neither strobe high, `mode_wdata` has no effect and the mode status stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_set_we | input | 1 | Set strobe for mode bits |
| mode_clr_we | input | 1 | Clear strobe for mode bits |
| mode_wdata | input | 32 | Bit mask used by either strobe |
| mode_stat | output | 32 | Current mode bits, 1 = open-drain |
| src_sel | input | 32 | Per-line source select, 1 = peripheral |
| ctl_data | input | 32 | Controller output values |
| ctl_oe | input | 32 | Controller output enables |
| per_data | input | 32 | Peripheral output values |
| per_oe | input | 32 | Peripheral output enables |
| pad_out | output | 32 | Value presented to each pad |
| pad_oe | output | 32 | Output enable presented to each pad |

## Verification
The assertions check the mode register's behaviour on every cycle: the reset value, set, clear, clear winning over set, and holding steady when no strobe is high. They also check that no open-drain line ever shows a 1 on its pad value. The bench's reference model is compared every cycle, and only its scenarios show the per-line source choice, the push-pull pass-through, and the exact open-drain enable rule under both controller and peripheral ownership. Those scenarios use mixed select, data and enable patterns, including lines that release with the enable on and lines that stay off with the enable off.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;
  typedef struct packed {
    logic val;
    logic en;
  } drv_pair_t;
endpackage

// File: rtl/mdrv_rst_sync.sv
module mdrv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mdrv_mode_reg.sv
module mdrv_mode_reg #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_we,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] mode_q
);
  logic [NUM_LINES-1:0] mode_d;
  logic                 mode_en;

  assign mode_en = set_we | clr_we;

  always_comb begin
    mode_d = mode_q;
    if (set_we) mode_d = mode_d | wdata;
    if (clr_we) mode_d = mode_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/mdrv_src_mux.sv
module mdrv_src_mux
  import mdrv_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0] sel,
  input  logic [NUM_LINES-1:0] a_val,
  input  logic [NUM_LINES-1:0] a_en,
  input  logic [NUM_LINES-1:0] b_val,
  input  logic [NUM_LINES-1:0] b_en,
  output drv_pair_t            chosen [NUM_LINES]
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb begin
      if (sel[i]) begin
        chosen[i].val = b_val[i];
        chosen[i].en  = b_en[i];
      end else begin
        chosen[i].val = a_val[i];
        chosen[i].en  = a_en[i];
      end
    end
  end
endmodule

// File: rtl/mdrv_od_convert.sv
module mdrv_od_convert
  import mdrv_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  drv_pair_t            chosen [NUM_LINES],
  input  logic [NUM_LINES-1:0] od_mode,
  output logic [NUM_LINES-1:0] pad_val,
  output logic [NUM_LINES-1:0] pad_en
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb begin
      if (od_mode[i]) begin
        pad_val[i] = 1'b0;
        pad_en[i]  = chosen[i].en & ~chosen[i].val;
      end else begin
        pad_val[i] = chosen[i].val;
        pad_en[i]  = chosen[i].en;
      end
    end
  end
endmodule

// File: rtl/mdrv_out_stage.sv
module mdrv_out_stage
  import mdrv_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_set_we,
  input  logic                 mode_clr_we,
  input  logic [NUM_LINES-1:0] mode_wdata,
  output logic [NUM_LINES-1:0] mode_stat,
  input  logic [NUM_LINES-1:0] src_sel,
  input  logic [NUM_LINES-1:0] ctl_data,
  input  logic [NUM_LINES-1:0] ctl_oe,
  input  logic [NUM_LINES-1:0] per_data,
  input  logic [NUM_LINES-1:0] per_oe,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);
  logic      rst_sync_n;
  drv_pair_t chosen [NUM_LINES];

  mdrv_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdrv_mode_reg #(.NUM_LINES(NUM_LINES)) u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (mode_set_we),
    .clr_we (mode_clr_we),
    .wdata  (mode_wdata),
    .mode_q (mode_stat)
  );

  mdrv_src_mux #(.NUM_LINES(NUM_LINES)) u_mux (
    .sel    (src_sel),
    .a_val  (ctl_data),
    .a_en   (ctl_oe),
    .b_val  (per_data),
    .b_en   (per_oe),
    .chosen (chosen)
  );

  mdrv_od_convert #(.NUM_LINES(NUM_LINES)) u_od (
    .chosen  (chosen),
    .od_mode (mode_stat),
    .pad_val (pad_out),
    .pad_en  (pad_oe)
  );
endmodule

// File: rtl/mdrv_out_stage_chk.sv
module mdrv_out_stage_chk #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_sync_n,
  input logic                 mode_set_we,
  input logic                 mode_clr_we,
  input logic [NUM_LINES-1:0] mode_wdata,
  input logic [NUM_LINES-1:0] mode_stat,
  input logic [NUM_LINES-1:0] pad_out
);
  // R1: a reset edge leaves the mode word at zero
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (mode_stat == '0));

  assert_set_only_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_set_we && !mode_clr_we) |=>
      (mode_stat == ($past(mode_stat) | $past(mode_wdata))));

  assert_clr_only_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_set_we && mode_clr_we) |=>
      (mode_stat == ($past(mode_stat) & ~$past(mode_wdata))));

  assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_set_we && mode_clr_we) |=>
      (mode_stat == ($past(mode_stat) & ~$past(mode_wdata))));

  assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_set_we && !mode_clr_we) |=> $stable(mode_stat));

  assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & mode_stat) == '0));
endmodule

bind mdrv_out_stage mdrv_out_stage_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sync_n  (rst_sync_n),
  .mode_set_we (mode_set_we),
  .mode_clr_we (mode_clr_we),
  .mode_wdata  (mode_wdata),
  .mode_stat   (mode_stat),
  .pad_out     (pad_out)
);

// File: tb/sim_mdrv_out_stage.sv
`timescale 1ns/100ps
module sim_mdrv_out_stage;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         set_we = 1'b0, clr_we = 1'b0;
  logic [N-1:0] wdata = '0, sel = '0, cd = '0, coe = '0, pd = '0, poe = '0;
  logic [N-1:0] stat, pout, poen;

  int    checks = 0, fails = 0, cyc = 0, since_rel = 0;
  string cur_req = "R1";
  logic [N-1:0] m_mode = '0;

  always #2.5 clk = ~clk;

  mdrv_out_stage u0 (
    .clk(clk), .rst_n(rst_n), .mode_set_we(set_we), .mode_clr_we(clr_we),
    .mode_wdata(wdata), .mode_stat(stat), .src_sel(sel), .ctl_data(cd),
    .ctl_oe(coe), .per_data(pd), .per_oe(poe), .pad_out(pout), .pad_oe(poen)
  );

  // reference model: mode bits plus the two-edge reset holdoff
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode    = '0;
      since_rel = 0;
    end else begin
      if (since_rel >= 2) begin
        if (set_we) m_mode = m_mode | wdata;
        if (clr_we) m_mode = m_mode & ~wdata;
      end
      since_rel++;
    end
  end

  task automatic chk(string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [N-1:0] e_out, e_oe;
    cyc++;
    for (int i = 0; i < N; i++) begin
      logic v, e;
      v = sel[i] ? pd[i] : cd[i];
      e = sel[i] ? poe[i] : coe[i];
      if (m_mode[i]) begin
        e_out[i] = 1'b0;
        e_oe[i]  = e & ~v;
      end else begin
        e_out[i] = v;
        e_oe[i]  = e;
      end
    end
    chk("mode_stat", stat, m_mode);
    chk("pad_out", pout, e_out);
    chk("pad_oe", poen, e_oe);
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic drive(logic s, logic c, logic [N-1:0] w, bit rnd_src);
    @(negedge clk);
    #1;
    set_we = s; clr_we = c; wdata = w;
    if (rnd_src) begin
      cd = $urandom; coe = $urandom; pd = $urandom; poe = $urandom;
    end
  endtask

  initial begin
    repeat (3) drive(0, 0, '0, 1);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (4) drive(0, 0, 32'hFFFF_FFFF, 1);
    // R5: source choice with all lines push-pull
    cur_req = "R5";
    sel = 32'h0000_0000; repeat (4) drive(0, 0, '0, 1);
    sel = 32'hFFFF_FFFF; repeat (4) drive(0, 0, '0, 1);
    // R6: push-pull pass-through, mixed select
    cur_req = "R6";
    sel = 32'hA5A5_0F0F; repeat (6) drive(0, 0, '0, 1);
    // R2: set strobes
    cur_req = "R2";
    drive(1, 0, 32'h0000_00FF, 1);
    drive(1, 0, 32'hF000_0000, 1);
    drive(0, 0, '0, 1);
    // R9: wdata toggles with no strobe
    cur_req = "R9";
    drive(0, 0, 32'hFFFF_FFFF, 1);
    drive(0, 0, 32'h1234_5678, 1);
    drive(0, 0, '0, 1);
    // R3: clear strobes
    cur_req = "R3";
    drive(0, 1, 32'h0000_000F, 1);
    drive(0, 0, '0, 1);
    // R4: both strobes, overlapping and fresh bits
    cur_req = "R4";
    drive(1, 0, 32'h0F0F_0F0F, 1);
    drive(1, 1, 32'h0000_FFFF, 1);
    drive(0, 0, '0, 1);
    // R7: all open-drain, controller-owned, including pad edge cases
    cur_req = "R7";
    drive(1, 0, 32'hFFFF_FFFF, 1);
    sel = '0;
    drive(0, 0, '0, 0); cd = '0; coe = '1;
    drive(0, 0, '0, 0); cd = '1; coe = '1;
    drive(0, 0, '0, 0); cd = '0; coe = '0;
    repeat (6) drive(0, 0, '0, 1);
    // R8: open-drain with peripheral ownership
    cur_req = "R8";
    sel = '1;
    drive(0, 0, '0, 0); pd = 32'h00FF_00FF; poe = 32'h0F0F_F0F0;
    repeat (6) drive(0, 0, '0, 1);
    // mixed modes and sources
    cur_req = "R7";
    for (int k = 0; k < 40; k++) begin
      sel = $urandom;
      drive(1'($urandom), 1'($urandom), $urandom, 1);
    end
    // R1: reset in the middle of operation
    cur_req = "R1";
    drive(1, 0, 32'hFFFF_FFFF, 1);
    rst_n = 1'b0;
    repeat (2) drive(0, 0, '0, 1);
    rst_n = 1'b1;
    repeat (4) drive(0, 0, '0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule